// File: doc/BRIEF.md
# Three-Element Structure De-interleaving Loader

This block fetches a packed array of three-element records, such as red/green/blue samples, from a 32-bit, byte-addressed synchronous memory. It splits the stream so that every first element lands in one 64-bit output vector, every second element in a second vector and every third element in a third vector. Elements may be 8, 16 or 32 bits wide. One operation always consumes 24 bytes. That is eight records of 8-bit elements, four records of 16-bit elements, or two records of 32-bit elements.

A one-cycle `start` pulse launches an operation. The loader reads whole words beginning at the base address rounded down to a multiple of four, so records may start at any byte address. When all three vectors are complete, it raises `done` for one cycle. At the same time it returns the base pointer, advanced past the consumed records if post-increment was requested.

Top module: `struct_deint_loader`

## Requirements
- R1: Element k (k = 0, 1, 2) of record s is placed in lane s of output vector k. With element width W bits there are 64/W lanes, and lane s occupies bits [s*W +: W].
- R2: `elem_size` selects the element width. Code 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits, and code 3 behaves as code 2.
- R3: Each element is assembled little-endian: its lowest-addressed byte becomes its least significant byte.
- R4: Reads use word-aligned addresses that start at the base rounded down to a multiple of 4 and rise by 4 per read. An operation issues 6 reads when base[1:0] is 0 and 7 reads otherwise.
- R5: Read data is taken from `mem_rdata` one cycle after the matching `mem_re`/`mem_addr` cycle.
- R6: In the `done` cycle, `next_addr` equals base + 24 when `post_inc` was high at start, and equals base otherwise.
- R7: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` lasts exactly one cycle, and `mem_re` is only high while `busy` is high.
- R8: A `start` pulse that arrives while `busy` is high is ignored and does not disturb the running operation.
- R9: After reset, `busy`, `done` and `mem_re` are low.
- R10: The three vectors and `next_addr` keep their `done`-cycle values until the next operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, accepted when idle |
| base_addr | input | AW | Byte address of the first record |
| elem_size | input | 2 | Element width code (R2) |
| post_inc | input | 1 | Return an advanced pointer when high |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Word-aligned byte address of the read |
| mem_rdata | input | 32 | Read data, valid one cycle after the strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vec0 | output | 64 | All first elements |
| vec1 | output | 64 | All second elements |
| vec2 | output | 64 | All third elements |
| next_addr | output | AW | Updated base pointer |

## Verification
Three kinds of internal fault reach the ports in different ways. A wrong word counter or word-capture index corrupts bytes in the output vectors. It can also change the number of strobes, which is visible as soon as `done` fires. A wrong byte-offset realignment shifts lanes only when the base is unaligned, so every base offset from 0 to 3 is exercised at every element width. A fault in the lane routing swaps or misplaces elements in the vectors, and byte-distinct memory contents expose any such swap in the first result.

// File: rtl/sdl_pkg.sv
// Shared definitions for the structure de-interleaving loader.
// Assumes a 32-bit memory word and three destination vectors.
package sdl_pkg;
    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_ALT = 2'd3
    } elem_sz_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_DRAIN,
        ST_FIN
    } seq_st_e;

    localparam int WORD_BYTES = 4;
    localparam int NUM_DEST   = 3;
endpackage

// File: rtl/sdl_seq.sv
// Read sequencer: latches the request and issues word reads from the
// rounded-down base. It tracks the one-cycle read latency and produces busy/done.
// Assumes TOTAL_BYTES is a multiple of the word size.
module sdl_seq
    import sdl_pkg::*;
#(
    parameter int AW          = 16,
    parameter int TOTAL_BYTES = 24,
    parameter int CW          = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [1:0]    elem_size,
    input  logic          post_inc,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic          cap_en,
    output logic [CW-1:0] cap_idx,
    output logic [1:0]    byte_off,
    output logic [1:0]    size_q,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] next_addr
);
    localparam int ALIGNED_WORDS = TOTAL_BYTES / WORD_BYTES;

    seq_st_e       st;
    logic [AW-1:0] base_q;
    logic          pinc_q;
    logic [CW-1:0] iss_cnt;
    logic [CW-1:0] cap_cnt;
    logic          rd_pend;
    logic [CW-1:0] last_idx;

    // Index of the last word: one more when the base is unaligned
    always_comb last_idx = (base_q[1:0] == 2'd0) ? CW'(ALIGNED_WORDS - 1) : CW'(ALIGNED_WORDS);

    // Control state, request latch and read/capture counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            base_q  <= '0;
            size_q  <= '0;
            pinc_q  <= 1'b0;
            iss_cnt <= '0;
            cap_cnt <= '0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= mem_re;
            if (rd_pend) cap_cnt <= cap_cnt + 1'b1;
            case (st)
                ST_IDLE: if (start) begin
                    base_q  <= base_addr;
                    size_q  <= elem_size;
                    pinc_q  <= post_inc;
                    iss_cnt <= '0;
                    cap_cnt <= '0;
                    st      <= ST_READ;
                end
                ST_READ: begin
                    iss_cnt <= iss_cnt + 1'b1;
                    if (iss_cnt == last_idx) st <= ST_DRAIN;
                end
                ST_DRAIN: if (rd_pend && cap_cnt == last_idx) st <= ST_FIN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Port-side decode of the sequencer state
    always_comb begin
        mem_re    = (st == ST_READ);
        mem_addr  = {base_q[AW-1:2], 2'b00} + AW'({iss_cnt, 2'b00});
        cap_en    = rd_pend;
        cap_idx   = cap_cnt;
        byte_off  = base_q[1:0];
        busy      = (st != ST_IDLE);
        done      = (st == ST_FIN);
        next_addr = pinc_q ? base_q + AW'(TOTAL_BYTES) : base_q;
    end
endmodule

// File: rtl/sdl_gather.sv
// Word collector: stores returned words and realigns them into a byte
// stream that starts at the base's byte offset.
// Assumes words arrive in rising address order.
module sdl_gather #(
    parameter int TOTAL_BYTES = 24,
    parameter int MAXW        = 7,
    parameter int CW          = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en,
    input  logic [CW-1:0]            cap_idx,
    input  logic [31:0]              mem_rdata,
    input  logic [1:0]               byte_off,
    output logic [8*TOTAL_BYTES-1:0] stream
);
    logic [31:0]         wbuf [MAXW];
    logic [32*MAXW-1:0]  flat;

    // Capture each returned word into its slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAXW; i++) wbuf[i] <= '0;
        end else if (cap_en && int'(cap_idx) < MAXW) begin
            wbuf[cap_idx] <= mem_rdata;
        end
    end

    // Flatten the words and drop the leading offset bytes
    always_comb begin
        for (int i = 0; i < MAXW; i++) flat[32*i +: 32] = wbuf[i];
        for (int n = 0; n < TOTAL_BYTES; n++)
            stream[8*n +: 8] = flat[8*(n + int'(byte_off)) +: 8];
    end
endmodule

// File: rtl/sdl_split.sv
// Lane router: transposes a record stream into three vectors for each
// element width and selects the variant named by the size code.
// Assumes three elements per record and VEC_W a multiple of 32.
module sdl_split
    import sdl_pkg::*;
#(
    parameter int VEC_W = 64
) (
    input  logic [3*VEC_W-1:0] stream,
    input  logic [1:0]         size_q,
    output logic [VEC_W-1:0]   vec0,
    output logic [VEC_W-1:0]   vec1,
    output logic [VEC_W-1:0]   vec2
);
    localparam int VB = VEC_W / 8;

    logic [VEC_W-1:0] lay [3][NUM_DEST];

    for (genvar m = 0; m < 3; m++) begin : g_width
        localparam int EB    = 1 << m;
        localparam int LANES = VB / EB;
        for (genvar k = 0; k < NUM_DEST; k++) begin : g_dest
            for (genvar s = 0; s < LANES; s++) begin : g_lane
                for (genvar b = 0; b < EB; b++) begin : g_byte
                    assign lay[m][k][8*(s*EB+b) +: 8] =
                        stream[8*((s*NUM_DEST+k)*EB+b) +: 8];
                end
            end
        end
    end

    // Pick the layout for the latched element width
    always_comb begin
        case (elem_sz_e'(size_q))
            SZ_B8:   begin vec0 = lay[0][0]; vec1 = lay[0][1]; vec2 = lay[0][2]; end
            SZ_B16:  begin vec0 = lay[1][0]; vec1 = lay[1][1]; vec2 = lay[1][2]; end
            default: begin vec0 = lay[2][0]; vec1 = lay[2][1]; vec2 = lay[2][2]; end
        endcase
    end
endmodule

// File: rtl/struct_deint_loader.sv
// Top: three-element structure de-interleaving loader. It reads 3*VEC_W/8
// bytes from any byte base and produces three transposed vectors.
// Assumes a 32-bit memory with one cycle of read latency.
module struct_deint_loader
    import sdl_pkg::*;
#(
    parameter int AW    = 16,
    parameter int VEC_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_addr,
    input  logic [1:0]       elem_size,
    input  logic             post_inc,
    output logic             mem_re,
    output logic [AW-1:0]    mem_addr,
    input  logic [31:0]      mem_rdata,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] vec0,
    output logic [VEC_W-1:0] vec1,
    output logic [VEC_W-1:0] vec2,
    output logic [AW-1:0]    next_addr
);
    localparam int TOTAL_BYTES = NUM_DEST * VEC_W / 8;
    localparam int MAXW        = TOTAL_BYTES / WORD_BYTES + 1;
    localparam int CW          = $clog2(MAXW + 1);

    logic                     cap_en;
    logic [CW-1:0]            cap_idx;
    logic [1:0]               byte_off;
    logic [1:0]               size_q;
    logic [8*TOTAL_BYTES-1:0] stream;

    sdl_seq #(.AW(AW), .TOTAL_BYTES(TOTAL_BYTES), .CW(CW)) u_seq (
        .clk, .rst_n, .start, .base_addr, .elem_size, .post_inc,
        .mem_re, .mem_addr, .cap_en, .cap_idx, .byte_off, .size_q,
        .busy, .done, .next_addr
    );

    sdl_gather #(.TOTAL_BYTES(TOTAL_BYTES), .MAXW(MAXW), .CW(CW)) u_gather (
        .clk, .rst_n, .cap_en, .cap_idx, .mem_rdata, .byte_off, .stream
    );

    sdl_split #(.VEC_W(VEC_W)) u_split (
        .stream, .size_q, .vec0, .vec1, .vec2
    );
endmodule

// File: rtl/struct_deint_loader_chk.sv
// Protocol checker for the de-interleaving loader, bound to the top.
// It keeps its own copy of the accepted request.
module struct_deint_loader_chk #(
    parameter int AW    = 16,
    parameter int VEC_W = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] base_addr,
    input logic          post_inc,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] next_addr
);
    logic [AW-1:0] exp_base;
    logic          exp_pinc;

    // Record the request that an idle loader accepts
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_base <= '0;
            exp_pinc <= 1'b0;
        end else if (start && !busy) begin
            exp_base <= base_addr;
            exp_pinc <= post_inc;
        end
    end

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_read_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> busy);
    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_addr[1:0] == 2'b00));
    assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);
    assert_next_ptr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> next_addr == (exp_pinc ? exp_base + AW'(3*VEC_W/8) : exp_base));
endmodule

bind struct_deint_loader struct_deint_loader_chk #(.AW(AW), .VEC_W(VEC_W)) u_chk (
    .clk, .rst_n, .start, .base_addr, .post_inc, .mem_re, .mem_addr,
    .busy, .done, .next_addr
);

// File: tb/struct_deint_loader_tb.sv
// Scoreboard bench: a driver task queues the expected result for each
// request, and a monitor compares every done pulse against the queue.
module struct_deint_loader_tb;
    localparam int AW = 16;

    typedef struct {
        logic [63:0]   v0, v1, v2;
        logic [AW-1:0] nxt;
        int            nreads;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [1:0]    elem_size = '0;
    logic          post_inc = 1'b0;
    logic          mem_re;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata = '0;
    logic          busy, done;
    logic [63:0]   vec0, vec1, vec2;
    logic [AW-1:0] next_addr;

    int   total = 0;
    int   bad   = 0;
    int   reads = 0;
    int   hold_checks = 0;
    exp_t sb[$];

    always #2 clk = ~clk;

    struct_deint_loader #(.AW(AW), .VEC_W(64)) u_dut (
        .clk, .rst_n, .start, .base_addr, .elem_size, .post_inc,
        .mem_re, .mem_addr, .mem_rdata, .busy, .done,
        .vec0, .vec1, .vec2, .next_addr
    );

    // Memory content: distinct byte at every address
    function automatic logic [7:0] mbyte(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    // Memory model with one cycle of read latency (R5)
    always @(posedge clk)
        if (mem_re)
            mem_rdata <= {mbyte(int'(mem_addr) + 3), mbyte(int'(mem_addr) + 2),
                          mbyte(int'(mem_addr) + 1), mbyte(int'(mem_addr))};

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: compute the expected result from the requirements and launch
    task automatic run_op(input int base, input logic [1:0] sz, input bit pinc,
                          input bit poke);
        exp_t e;
        int   bytes, lanes;
        logic [31:0] el;
        bytes = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;   // R2
        lanes = 8 / bytes;
        e.v0 = '0; e.v1 = '0; e.v2 = '0;
        for (int m = 0; m < 3 * lanes; m++) begin
            el = '0;
            for (int b = 0; b < bytes; b++)                 // R3 little-endian
                el[8*b +: 8] = mbyte(base + m * bytes + b);
            case (m % 3)                                    // R1 routing
                0: e.v0[(m/3)*bytes*8 +: 32] = el;
                1: e.v1[(m/3)*bytes*8 +: 32] = el;
                default: e.v2[(m/3)*bytes*8 +: 32] = el;
            endcase
        end
        e.nxt    = pinc ? AW'(base + 24) : AW'(base);       // R6
        e.nreads = (base % 4 == 0) ? 6 : 7;                 // R4
        sb.push_back(e);
        @(negedge clk);
        base_addr = AW'(base); elem_size = sz; post_inc = pinc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin                                     // R8 start while busy
            @(negedge clk);
            base_addr = AW'(base + 40); elem_size = ~sz; post_inc = ~pinc; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        // R10: results held after done
        repeat (3) @(negedge clk);
        check(vec0 == e.v0 && vec1 == e.v1 && vec2 == e.v2, "R10", "held vectors",
              vec0 ^ vec1 ^ vec2, e.v0 ^ e.v1 ^ e.v2);
        check(next_addr == e.nxt, "R10", "held pointer", 64'(next_addr), 64'(e.nxt));
        hold_checks++;
    endtask

    // Monitor: count strobes and score each completion
    always @(negedge clk) begin
        if (rst_n && mem_re) begin
            reads++;
            check(busy, "R7", "mem_re outside busy", 64'(busy), 64'd1);
        end
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(vec0 == e.v0, "R1", "vec0", vec0, e.v0);
                check(vec1 == e.v1, "R1", "vec1", vec1, e.v1);
                check(vec2 == e.v2, "R3", "vec2", vec2, e.v2);
                check(next_addr == e.nxt, "R6", "next_addr", 64'(next_addr), 64'(e.nxt));
                check(reads == e.nreads, "R4", "read count", 64'(reads), 64'(e.nreads));
                check(busy, "R7", "busy in done cycle", 64'(busy), 64'd1);
            end
            reads = 0;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R7", "watchdog expired", 64'd0, 64'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !mem_re, "R9", "reset outputs",
              64'({busy, done, mem_re}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R4 R5: every width at every byte offset, with and without post-increment
        for (int sz = 0; sz < 4; sz++)
            for (int off = 0; off < 4; off++)
                run_op(16 * sz + off + 4, 2'(sz), off[0], 1'b0);
        // R8: start pulses during busy are ignored
        run_op(101, 2'd1, 1'b1, 1'b1);
        run_op(64, 2'd0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7", "pending results", 64'(sb.size()), 64'd0);
        check(!busy && !done, "R7", "idle at end", 64'({busy, done}), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule